// File: doc/BRIEF.md
# Buck Converter Soft-Start and Fault Sequencer

This block is the digital supervisor of a synchronous step-down converter controller. It runs on a fast system clock and advances its sequencing state only on a cycle tick, which is asserted once per switching period. Three comparator results arrive as raw digital levels:
- supply too low;
- error-amplifier output pulled below the shutdown level;
- feedback below its short-circuit threshold.

The block drives a 10-bit reference code for an external DAC. It also drives a select bit that tells the analog side which feedback short threshold to use, and one enable each for the high-side and low-side gate drivers.

After reset, or after the supply recovers, the sequencer ramps the reference code from zero to full scale, one step per tick. It then sits in a run state. The short-circuit detector is masked until the ramp has passed its midpoint. From then on, a short seen on eight consecutive ticks turns the drivers off and latches. Only a supply undervoltage episode clears that latch. A shutdown request on the compensation node turns the drivers off and restarts the ramp from zero once it is released. A supply undervoltage turns the drivers off at once, without waiting for a tick, and recovery restarts the ramp, which gives hiccup behaviour.

Top module: `buck_softstart_seq`

## Requirements
- R1: While `rst_n` is low, both driver enables, `ramp_done_o`, `fb_thr_fixed_o` and `ref_code_o` are 0.
- R2: During the ramp, `ref_code_o` starts at 0 when the drivers turn on and rises by exactly 1 on every ticked edge. It reaches 1023 after 1023 ticks. On that same edge `ramp_done_o` goes to 1, and the code then holds at 1023 with both drivers enabled.
- R3: State and reference code change only on rising edges where `cyc_tick_i` is 1. With the tick low, `ref_code_o` holds its value.
- R4: While the synchronized shutdown input is 1, the next ticked edge forces both enables to 0, `ref_code_o` to 0 and `ramp_done_o` to 0. They stay there for as long as the input is held.
- R5: When the shutdown input is released, the next ticked edge starts a new ramp. The enables go to 1 with `ref_code_o` equal to 0.
- R6: While `ref_code_o` is below 512 in the ramp, `fb_low_i` has no effect: the drivers stay enabled.
- R7: Once armed (ramp code at 512 or above, or in run), `fb_low_i` seen on 8 consecutive ticks turns both enables off on the 8th tick and clears `ref_code_o`. Any tick with the input low restarts the count.
- R8: After a short trip, the enables stay 0 and the code stays 0. Removing the short does not release this, and neither does pulsing the shutdown input.
- R9: A synchronized supply-low level forces both enables to 0 with no tick needed. The next tick clears the code and any latched short. When the supply recovers, a new ramp starts from 0.
- R10: `fb_thr_fixed_o` is 0 (threshold tracks half the reference) outside the run state and 1 (fixed threshold) in the run state.
- R11: Each comparator input passes through two synchronizer flops. With the tick high, a change at an input takes effect at the third rising edge after it is applied.
- R12: Supply-low takes priority over the latched short, which takes priority over shutdown. If shutdown is still held when the supply recovers, the drivers stay off until shutdown is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cyc_tick_i | input | 1 | One-cycle strobe per switching period; enables sequencing |
| vcc_low_i | input | 1 | Raw supply-undervoltage comparator level |
| comp_off_i | input | 1 | Raw compensation-node shutdown comparator level |
| fb_low_i | input | 1 | Raw feedback short comparator level |
| ref_code_o | output | 10 | Reference code for the external DAC |
| fb_thr_fixed_o | output | 1 | 1: fixed short threshold, 0: half of present reference |
| hs_drv_en_o | output | 1 | High-side driver enable |
| ls_drv_en_o | output | 1 | Low-side driver enable |
| ramp_done_o | output | 1 | Ramp finished, run state |

## Verification
Tests run with the tick held high except where tick gating is under test. A shutdown, release or short level applied at a falling edge acts at the third rising edge: two synchronizer flops, then the state register. A supply-low level removes the driver enables at the second rising edge, even with the tick held low. A short that stays asserted trips on the tenth rising edge after it is applied, or on the eighth ticked edge after the ramp code reads 512. Each task drives inputs at a falling edge, counts the exact number of rising edges to the due edge, and samples at the falling edge one edge before and one edge after that point.

// File: rtl/buck_seq_pkg.sv
package buck_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RAMP = 2'd1,
    SEQ_RUN  = 2'd2,
    SEQ_TRIP = 2'd3
  } seq_state_e;

endpackage

// File: rtl/seq_sync.sv
module seq_sync #(
  parameter int             W       = 1,
  parameter int             DEPTH   = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= RST_VAL;
          else        stage_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[i] <= RST_VAL;
          else        stage_q[i] <= stage_q[i-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[DEPTH-1];

endmodule

// File: rtl/seq_ramp_cnt.sv
module seq_ramp_cnt #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt_o,
  output logic          half_o,
  output logic          last_o
);

  localparam logic [CW-1:0] LAST_STEP = {{(CW-1){1'b1}}, 1'b0};

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (tick) begin
      if (clr)      cnt_d = '0;
      else if (inc) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign half_o = cnt_q[CW-1];
  assign last_o = (cnt_q == LAST_STEP);

endmodule

// File: rtl/seq_short_filt.sv
module seq_short_filt #(
  parameter int LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic armed,
  input  logic hit,
  output logic trip_o
);

  localparam int            FW   = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [FW-1:0] FULL = FW'(LEN - 1);

  logic [FW-1:0] run_q, run_d;
  logic          seen;

  assign seen   = armed && hit;
  assign trip_o = tick && seen && (run_q == FULL);

  always_comb begin
    run_d = run_q;
    if (tick) begin
      if (!seen)              run_d = '0;
      else if (run_q != FULL) run_d = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import buck_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       uv_s,
  input  logic       comp_s,
  input  logic       trip,
  input  logic       half,
  input  logic       last,
  output seq_state_e state_o,
  output logic       cnt_clr,
  output logic       cnt_inc,
  output logic       armed
);

  seq_state_e cur_q, nxt, cur_d;

  always_comb begin
    nxt = cur_q;
    if (uv_s) begin
      nxt = SEQ_IDLE;
    end else if (cur_q == SEQ_TRIP) begin
      nxt = SEQ_TRIP;
    end else if (comp_s) begin
      nxt = SEQ_IDLE;
    end else begin
      case (cur_q)
        SEQ_IDLE: nxt = SEQ_RAMP;
        SEQ_RAMP: begin
          if (trip)      nxt = SEQ_TRIP;
          else if (last) nxt = SEQ_RUN;
          else           nxt = SEQ_RAMP;
        end
        SEQ_RUN:  nxt = trip ? SEQ_TRIP : SEQ_RUN;
        default:  nxt = SEQ_IDLE;
      endcase
    end
  end

  assign cur_d = tick ? nxt : cur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= SEQ_IDLE;
    else        cur_q <= cur_d;
  end

  assign cnt_inc = (cur_q == SEQ_RAMP) && ((nxt == SEQ_RAMP) || (nxt == SEQ_RUN));
  assign cnt_clr = (nxt == SEQ_IDLE) || (nxt == SEQ_TRIP);
  assign armed   = (cur_q == SEQ_RUN) || ((cur_q == SEQ_RAMP) && half);
  assign state_o = cur_q;

endmodule

// File: rtl/buck_softstart_seq.sv
module buck_softstart_seq
  import buck_seq_pkg::*;
#(
  parameter int RAMP_BITS  = 10,
  parameter int FILT_TICKS = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cyc_tick_i,
  input  logic                 vcc_low_i,
  input  logic                 comp_off_i,
  input  logic                 fb_low_i,
  output logic [RAMP_BITS-1:0] ref_code_o,
  output logic                 fb_thr_fixed_o,
  output logic                 hs_drv_en_o,
  output logic                 ls_drv_en_o,
  output logic                 ramp_done_o
);

  localparam int NUM_IN = 3;

  logic              rst_int_n;
  logic [NUM_IN-1:0] raw_in, syn_in;
  logic              uv_s, comp_s, fb_s;
  logic              cnt_clr, cnt_inc, armed, trip, half, last;
  logic              drv_on;
  seq_state_e        state;

  // internal reset: asserts at once, releases after two clocks
  seq_sync #(.W(1), .DEPTH(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (1'b1),
    .q    (rst_int_n)
  );

  // supply-low resets to asserted so nothing starts before it is sampled
  assign raw_in = {vcc_low_i, comp_off_i, fb_low_i};

  seq_sync #(.W(NUM_IN), .DEPTH(SYNC_DEPTH), .RST_VAL(3'b100)) u_in_sync (
    .clk  (clk),
    .rst_n(rst_int_n),
    .d    (raw_in),
    .q    (syn_in)
  );

  assign uv_s   = syn_in[2];
  assign comp_s = syn_in[1];
  assign fb_s   = syn_in[0];

  seq_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .tick   (cyc_tick_i),
    .uv_s   (uv_s),
    .comp_s (comp_s),
    .trip   (trip),
    .half   (half),
    .last   (last),
    .state_o(state),
    .cnt_clr(cnt_clr),
    .cnt_inc(cnt_inc),
    .armed  (armed)
  );

  seq_ramp_cnt #(.CW(RAMP_BITS)) u_ramp (
    .clk   (clk),
    .rst_n (rst_int_n),
    .tick  (cyc_tick_i),
    .clr   (cnt_clr),
    .inc   (cnt_inc),
    .cnt_o (ref_code_o),
    .half_o(half),
    .last_o(last)
  );

  seq_short_filt #(.LEN(FILT_TICKS)) u_filt (
    .clk   (clk),
    .rst_n (rst_int_n),
    .tick  (cyc_tick_i),
    .armed (armed),
    .hit   (fb_s),
    .trip_o(trip)
  );

  // supply-low removes drive without waiting for a tick
  assign drv_on         = ((state == SEQ_RAMP) || (state == SEQ_RUN)) && !uv_s;
  assign hs_drv_en_o    = drv_on;
  assign ls_drv_en_o    = drv_on;
  assign ramp_done_o    = (state == SEQ_RUN);
  assign fb_thr_fixed_o = (state == SEQ_RUN);

endmodule

// File: rtl/buck_seq_checker.sv
module buck_seq_checker
  import buck_seq_pkg::*;
#(
  parameter int CW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          uv_s,
  input seq_state_e    state,
  input logic [CW-1:0] ref_code,
  input logic          hs_en,
  input logic          ls_en,
  input logic          done
);

  assert_hold_no_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(ref_code));

  assert_ramp_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && hs_en && !done) |=>
      ((ref_code == $past(ref_code) + CW'(1)) || (ref_code == '0)));

  assert_done_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ref_code == '1));

  assert_mask_early_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (state == SEQ_RAMP) && !ref_code[CW-1]) |=> (state != SEQ_TRIP));

  assert_trip_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == SEQ_TRIP) && !uv_s) |=> (state == SEQ_TRIP));

  assert_uv_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    uv_s |-> (!hs_en && !ls_en));

  assert_idle_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == SEQ_IDLE) || (state == SEQ_TRIP)) |-> (!hs_en && !ls_en && (ref_code == '0)));

endmodule

bind buck_softstart_seq buck_seq_checker #(.CW(RAMP_BITS)) u_seq_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick    (cyc_tick_i),
  .uv_s    (uv_s),
  .state   (state),
  .ref_code(ref_code_o),
  .hs_en   (hs_drv_en_o),
  .ls_en   (ls_drv_en_o),
  .done    (ramp_done_o)
);

// File: tb/test_buck_softstart_seq.sv
module test_buck_softstart_seq;

  localparam int CLK_PERIOD = 10;
  localparam int CW         = 10;
  localparam int TOP        = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n, tick, vcc_low, comp_off, fb_low;
  logic [CW-1:0] ref_code;
  logic          thr_fixed, hs_en, ls_en, done;

  int n_checks = 0;
  int n_errs   = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  buck_softstart_seq i_buck_softstart_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .cyc_tick_i    (tick),
    .vcc_low_i     (vcc_low),
    .comp_off_i    (comp_off),
    .fb_low_i      (fb_low),
    .ref_code_o    (ref_code),
    .fb_thr_fixed_o(thr_fixed),
    .hs_drv_en_o   (hs_en),
    .ls_drv_en_o   (ls_en),
    .ramp_done_o   (done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_done(input string req);
    int k = 0;
    while (!done && k < 1200) begin
      step(1);
      k++;
    end
    chk(done, req, done, 1);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
  endtask

  task automatic test_reset();
    rst_n = 1'b0; tick = 1'b1; vcc_low = 1'b0; comp_off = 1'b0; fb_low = 1'b0;
    step(4);
    chk(!hs_en && !ls_en, "R1 drivers off in reset", hs_en, 0);
    chk(ref_code == 0, "R1 code zero in reset", ref_code, 0);
    chk(!done && !thr_fixed, "R1 done/threshold low in reset", done, 0);
    rst_n = 1'b1;
  endtask

  task automatic test_first_ramp();
    int k = 0;
    int steps = 0;
    int prev;
    bit mono = 1'b1;
    bit thr_ok = 1'b1;
    while (!hs_en && k < 20) begin
      step(1);
      k++;
    end
    chk(hs_en && ls_en, "R2 drivers on at ramp start", hs_en, 1);
    chk(ref_code == 0, "R2 ramp starts at zero", ref_code, 0);
    prev = ref_code;
    while (!done && steps < 1100) begin
      step(1);
      steps++;
      if (int'(ref_code) != prev + 1) mono = 1'b0;
      if (!done && thr_fixed) thr_ok = 1'b0;
      prev = ref_code;
    end
    chk(mono, "R2 code rises by one per tick", mono, 1);
    chk(steps == TOP, "R2 ramp length in ticks", steps, TOP);
    chk(ref_code == TOP, "R2 code at full scale", ref_code, TOP);
    chk(thr_ok, "R10 tracking threshold during ramp", thr_ok, 1);
    chk(thr_fixed, "R10 fixed threshold in run", thr_fixed, 1);
    step(5);
    chk(done && hs_en && ls_en && ref_code == TOP, "R2 run holds", ref_code, TOP);
  endtask

  task automatic test_comp_shutdown();
    bit ok = 1'b1;
    comp_off = 1'b1;
    step(2);
    chk(hs_en, "R11 shutdown not yet through synchronizer", hs_en, 1);
    step(1);
    chk(!hs_en && !ls_en, "R4 drivers off on shutdown", hs_en, 0);
    chk(ref_code == 0 && !done, "R4 code cleared on shutdown", ref_code, 0);
    chk(!thr_fixed, "R10 threshold select outside run", thr_fixed, 0);
    repeat (20) begin
      step(1);
      if (hs_en || ls_en || ref_code != 0) ok = 1'b0;
    end
    chk(ok, "R4 held off while shutdown asserted", ok, 1);
  endtask

  task automatic test_comp_restart();
    int r0;
    comp_off = 1'b0;
    step(2);
    chk(!hs_en, "R11 release not yet through synchronizer", hs_en, 0);
    step(1);
    chk(hs_en && ls_en, "R5 drivers on after release", hs_en, 1);
    chk(ref_code == 0, "R5 restart from zero", ref_code, 0);
    step(1);
    chk(ref_code == 1, "R5 ramp advancing", ref_code, 1);
    r0 = ref_code;
    for (int i = 0; i < 30; i++) begin
      tick = (i % 3 == 0);
      step(1);
    end
    chk(int'(ref_code) == r0 + 10, "R3 advance only on ticks", ref_code, r0 + 10);
    tick = 1'b0;
    r0 = ref_code;
    step(6);
    chk(int'(ref_code) == r0, "R3 hold without tick", ref_code, r0);
    tick = 1'b1;
  endtask

  task automatic test_mask_and_trip();
    int k = 0;
    bit ok = 1'b1;
    fb_low = 1'b1;
    while (ref_code != 512 && k < 600) begin
      step(1);
      k++;
      if (!hs_en) ok = 1'b0;
    end
    chk(ok, "R6 short ignored in first half", ok, 1);
    chk(ref_code == 512, "R6 ramp reached midpoint", ref_code, 512);
    step(7);
    chk(hs_en && ref_code == 519, "R7 no trip before 8 ticks", ref_code, 519);
    step(1);
    chk(!hs_en && !ls_en, "R7 trip on 8th armed tick", hs_en, 0);
    chk(ref_code == 0, "R7 code cleared on trip", ref_code, 0);
  endtask

  task automatic test_latch_hold();
    bit ok = 1'b1;
    fb_low = 1'b0;
    step(10);
    chk(!hs_en && !ls_en, "R8 removing short does not release", hs_en, 0);
    comp_off = 1'b1;
    step(10);
    comp_off = 1'b0;
    repeat (30) begin
      step(1);
      if (hs_en || ls_en || ref_code != 0 || done) ok = 1'b0;
    end
    chk(ok, "R8 shutdown pulse does not release latch", ok, 1);
  endtask

  task automatic test_power_cycle();
    vcc_low = 1'b1;
    step(5);
    chk(!hs_en && !ls_en, "R9 off during supply low", hs_en, 0);
    vcc_low = 1'b0;
    step(2);
    chk(!hs_en, "R11 supply release latency", hs_en, 0);
    step(1);
    chk(hs_en && ls_en && ref_code == 0, "R12 supply cycle clears latch, ramp from zero", hs_en, 1);
    wait_done("R9 ramp completes after power cycle");
  endtask

  task automatic test_filter_gap();
    bit ok = 1'b1;
    repeat (3) begin
      fb_low = 1'b1;
      for (int i = 0; i < 7; i++) begin
        step(1);
        if (!hs_en) ok = 1'b0;
      end
      fb_low = 1'b0;
      step(1);
      if (!hs_en) ok = 1'b0;
    end
    step(4);
    chk(ok && hs_en, "R7 gap restarts filter count", hs_en, 1);
    fb_low = 1'b1;
    step(9);
    chk(hs_en, "R7 run-state short before filter full", hs_en, 1);
    step(1);
    chk(!hs_en && !ls_en && !done, "R7 run-state short trips", hs_en, 0);
    fb_low = 1'b0;
    vcc_low = 1'b1;
    step(4);
    vcc_low = 1'b0;
    wait_done("R9 hiccup restart reaches run");
  endtask

  task automatic test_uv_immediate();
    tick = 1'b0;
    vcc_low = 1'b1;
    step(1);
    chk(hs_en, "R11 supply-low one edge in", hs_en, 1);
    step(1);
    chk(!hs_en && !ls_en, "R9 drivers off without tick", hs_en, 0);
    chk(ref_code == TOP && done, "R3 state held without tick", ref_code, TOP);
    tick = 1'b1;
    step(1);
    chk(ref_code == 0 && !done, "R9 tick clears code on supply low", ref_code, 0);
    comp_off = 1'b1;
    step(3);
    vcc_low = 1'b0;
    step(6);
    chk(!hs_en && !ls_en, "R12 shutdown still holds after supply recovers", hs_en, 0);
    comp_off = 1'b0;
    step(3);
    chk(hs_en && ref_code == 0, "R12 ramp restarts after shutdown release", hs_en, 1);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errs++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      report();
      $finish;
    end
  end

  initial begin
    test_reset();
    test_first_ramp();
    test_comp_shutdown();
    test_comp_restart();
    test_mask_and_trip();
    test_latch_hold();
    test_power_cycle();
    test_filter_gap();
    test_uv_immediate();
    finished = 1'b1;
    report();
    $finish;
  end

endmodule